// File: doc/BRIEF.md
# Pin Bank Controller with Separate Set and Clear Output Registers

This block controls a bank of general-purpose pins (up to 64) from a single 64-bit register port. Software raises output bits by writing ones to a set register and lowers them by writing ones to a separate clear register, so several agents can change different lines without a read-modify-write. The same offset as the set register reads back the output latch. A data register returns the sampled pin levels.

Every line has its own configuration word. The word holds an output enable, a polarity inverter that applies both to what the line drives and to what it reads back, an open-drain option, and an ownership field. A nonzero ownership field hands the pad to another function. Pad controls come from registers, and read data comes back one cycle after the request. A constant register reports the line count and a base interrupt-vector index fixed at build time.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset the output latch and every configuration word are zero, `pad_oe` and `pad_out` are all zero, and `rsp_rdata` is zero.
- R2: A write to offset 0x8 sets each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged. A read of offset 0x8 returns the latch, with bits at or above NUM_LINES reading as zero.
- R3: A write to offset 0x10 clears each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged. A read of offset 0x10 returns zero.
- R4: A read of offset 0x0 returns, for each line n, `pad_in[n]` XOR that line's invert bit, with bits at or above NUM_LINES reading as zero. Any read returns its data on `rsp_rdata` in the cycle after the request.
- R5: The configuration word of line n is at offset 0x400 + 8*n. Within it, bit 0 is output enable, bit 1 is invert, bit 12 is open-drain and bits 25:16 are the ownership field. A read of the word returns only these fields, with all other bits zero. For a line number at or above NUM_LINES, writes do nothing and reads return zero.
- R6: For an owned-free line in push-pull mode (ownership 0, open-drain 0), `pad_oe` equals the output-enable bit and `pad_out` equals latch XOR invert. Both take effect one clock after the state that drives them changes.
- R7: In open-drain mode the driven value is latch XOR invert XOR 1. `pad_out` is 0, and `pad_oe` is asserted only when the output enable is set and the driven value is 0.
- R8: A line with a nonzero ownership field has `pad_oe` and `pad_out` at 0 whatever its latch and configuration bits hold. Its latch bit can still be set, cleared and read.
- R9: A read of offset 0x90 returns NUM_LINES in bits 7:0 and VEC_BASE in bits 15:8, with all other bits zero. Writes to offset 0x90 and to offset 0x0 have no effect.
- R10: A request whose address has nonzero bits 2:0, or that falls on no mapped register, changes no state and reads as zero. In any cycle after which no read was requested, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, registered, one cycle after the request |
| pad_in | input | NUM_LINES | Sampled pin levels |
| pad_out | output | NUM_LINES | Value driven to each pad |
| pad_oe | output | NUM_LINES | Pad driver enable |

## Verification
The bench checks that zeros in set or clear write data leave the latch alone and that an all-ones clear empties it. A design that reused one register for both operations would lose unrelated bits. It checks open-drain polarity in both latch states and with the inverter on. A design that left out the extra inversion would enable the pad exactly when it should release it. It also checks that an owned line stays released while its latch still reads back. Finally, it checks that misaligned addresses, unmapped addresses, the constant register and out-of-range line numbers take writes without effect. A sloppy decoder would alias these onto the latch or onto line 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned OFF_DAT   = 'h000;
  localparam int unsigned OFF_SET   = 'h008;
  localparam int unsigned OFF_CLR   = 'h010;
  localparam int unsigned OFF_CONST = 'h090;
  localparam int unsigned OFF_CFG   = 'h400;

  typedef struct packed {
    logic [9:0] owner;
    logic       od;
    logic       inv;
    logic       oe;
  } line_cfg_t;

  function automatic logic [63:0] cfg_to_word(line_cfg_t c);
    logic [63:0] w;
    w        = '0;
    w[0]     = c.oe;
    w[1]     = c.inv;
    w[12]    = c.od;
    w[25:16] = c.owner;
    return w;
  endfunction
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_dat,
  output logic              hit_set,
  output logic              hit_clr,
  output logic              hit_const,
  output logic              hit_cfg,
  output logic [LINE_W-1:0] cfg_idx
);
  import gpio_bank_pkg::*;

  logic              aligned;
  logic [ADDR_W-1:0] cfg_off;
  logic [ADDR_W-4:0] word_idx;

  assign aligned   = (addr[2:0] == 3'b000);
  assign cfg_off   = addr - ADDR_W'(OFF_CFG);
  assign word_idx  = cfg_off[ADDR_W-1:3];
  assign hit_dat   = (addr == ADDR_W'(OFF_DAT));
  assign hit_set   = (addr == ADDR_W'(OFF_SET));
  assign hit_clr   = (addr == ADDR_W'(OFF_CLR));
  assign hit_const = (addr == ADDR_W'(OFF_CONST));
  assign hit_cfg   = aligned && (addr >= ADDR_W'(OFF_CFG)) &&
                     (32'(word_idx) < NUM_LINES);
  assign cfg_idx   = word_idx[LINE_W-1:0];
endmodule

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [LINE_W-1:0]           idx,
  input  logic [63:0]                 wdata,
  output line_cfg_t [NUM_LINES-1:0]   cfg_q
);
  logic unused_bits;
  assign unused_bits = ^{wdata[63:26], wdata[15:13], wdata[11:2]};

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[n] <= '0;
      end else if (we && (32'(idx) == n)) begin
        cfg_q[n].oe    <= wdata[0];
        cfg_q[n].inv   <= wdata[1];
        cfg_q[n].od    <= wdata[12];
        cfg_q[n].owner <= wdata[25:16];
      end
    end
  end
endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad
  import gpio_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      latch_bit,
  input  line_cfg_t cfg,
  output logic      pad_o,
  output logic      pad_en
);
  logic drive_v;
  logic owned;
  logic nxt_o;
  logic nxt_en;

  assign drive_v = latch_bit ^ cfg.inv ^ cfg.od;
  assign owned   = |cfg.owner;

  always_comb begin
    if (owned) begin
      nxt_o  = 1'b0;
      nxt_en = 1'b0;
    end else if (cfg.od) begin
      nxt_o  = 1'b0;
      nxt_en = cfg.oe & ~drive_v;
    end else begin
      nxt_o  = drive_v;
      nxt_en = cfg.oe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_en <= 1'b0;
    end else begin
      pad_o  <= nxt_o;
      pad_en <= nxt_en;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12,
  parameter int VEC_BASE  = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic [63:0]          rsp_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic                      hit_dat, hit_set, hit_clr, hit_const, hit_cfg;
  logic [LINE_W-1:0]         cfg_idx;
  line_cfg_t [NUM_LINES-1:0] cfg_q;
  logic [NUM_LINES-1:0]      out_q;
  logic [NUM_LINES-1:0]      inv_vec, od_vec, own_vec;
  logic [NUM_LINES-1:0]      set_mask, clr_mask;
  logic                      wr, rd;
  logic [63:0]               rd_next;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  gpio_bank_decode #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_dec (
    .addr(req_addr), .hit_dat(hit_dat), .hit_set(hit_set), .hit_clr(hit_clr),
    .hit_const(hit_const), .hit_cfg(hit_cfg), .cfg_idx(cfg_idx)
  );

  gpio_bank_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk(clk), .rst(rst), .we(wr && hit_cfg), .idx(cfg_idx),
    .wdata(req_wdata), .cfg_q(cfg_q)
  );

  // Clear is applied after set, so a line hit by both ends low.
  assign set_mask = (wr && hit_set) ? req_wdata[NUM_LINES-1:0] : '0;
  assign clr_mask = (wr && hit_clr) ? req_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= (out_q | set_mask) & ~clr_mask;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_pad
    assign inv_vec[n] = cfg_q[n].inv;
    assign od_vec[n]  = cfg_q[n].od;
    assign own_vec[n] = |cfg_q[n].owner;
    gpio_bank_pad u_pad (
      .clk(clk), .rst(rst), .latch_bit(out_q[n]), .cfg(cfg_q[n]),
      .pad_o(pad_out[n]), .pad_en(pad_oe[n])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd) begin
      if (hit_dat)        rd_next[NUM_LINES-1:0] = pad_in ^ inv_vec;
      else if (hit_set)   rd_next[NUM_LINES-1:0] = out_q;
      else if (hit_const) rd_next[15:0] = {8'(VEC_BASE), 8'(NUM_LINES)};
      else if (hit_cfg)   rd_next = cfg_to_word(cfg_q[cfg_idx]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_rdata <= '0;
    else     rsp_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [63:0]          req_wdata,
  input logic [63:0]          rsp_rdata,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic [NUM_LINES-1:0] out_q,
  input logic [NUM_LINES-1:0] od_vec,
  input logic [NUM_LINES-1:0] own_vec
);
  import gpio_bank_pkg::*;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && rsp_rdata == '0))
    else $error("R1 outputs not quiet after reset");

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(OFF_SET)) |=>
      out_q == ($past(out_q) | $past(req_wdata[NUM_LINES-1:0])))
    else $error("R2 set register misbehaved");

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(OFF_CLR)) |=>
      out_q == ($past(out_q) & ~$past(req_wdata[NUM_LINES-1:0])))
    else $error("R3 clear register misbehaved");

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & $past(od_vec)) == '0))
    else $error("R7 open-drain line drove high");

  assert_owned_released_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_oe | pad_out) & $past(own_vec)) == '0))
    else $error("R8 owned line not released");

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> rsp_rdata == '0)
    else $error("R10 read data without a read");
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .out_q(out_q), .od_vec(od_vec),
  .own_vec(own_vec)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int N  = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [63:0]   req_wdata = '0;
  logic [63:0]   rsp_rdata;
  logic [N-1:0]  pad_in = 64'hA5A5_0000_1234_5678;
  logic [N-1:0]  pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_bank #(.NUM_LINES(N), .ADDR_W(AW), .VEC_BASE(48)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic          wr;
    logic [11:0]   addr;
    logic [63:0]   data;   // write data, or expected read data
    logic [3:0]    req;
  } vec_t;

  // R2 set, R3 clear, R9 constant register, R10 misaligned/unmapped
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h008, 64'h0000_0000_0000_F00F, 4'd2},
    '{1'b0, 12'h008, 64'h0000_0000_0000_F00F, 4'd2},
    '{1'b1, 12'h008, 64'h0000_0000_0000_0F00, 4'd2},
    '{1'b0, 12'h008, 64'h0000_0000_0000_FF0F, 4'd2},
    '{1'b1, 12'h010, 64'h0000_0000_0000_0103, 4'd3},
    '{1'b0, 12'h008, 64'h0000_0000_0000_FE0C, 4'd3},
    '{1'b0, 12'h010, 64'h0,                   4'd3},
    '{1'b1, 12'h010, 64'h0,                   4'd3},
    '{1'b0, 12'h008, 64'h0000_0000_0000_FE0C, 4'd3},
    '{1'b0, 12'h090, 64'h0000_0000_0000_3040, 4'd9},
    '{1'b1, 12'h090, 64'h0000_0000_0000_FFFF, 4'd9},
    '{1'b0, 12'h090, 64'h0000_0000_0000_3040, 4'd9},
    '{1'b1, 12'h009, 64'hFFFF_FFFF_FFFF_FFFF, 4'd10},
    '{1'b0, 12'h008, 64'h0000_0000_0000_FE0C, 4'd10},
    '{1'b0, 12'h009, 64'h0,                   4'd10},
    '{1'b1, 12'h018, 64'hFFFF_FFFF_FFFF_FFFF, 4'd10},
    '{1'b0, 12'h008, 64'h0000_0000_0000_FE0C, 4'd10},
    '{1'b1, 12'h008, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2},
    '{1'b0, 12'h008, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2},
    '{1'b1, 12'h010, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3},
    '{1'b0, 12'h008, 64'h0,                   4'd3}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic settle;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [11:0] cfg_addr(input int n);
    return 12'(32'h400 + 8 * n);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_out", 64'(pad_out), 64'h0);
    chk("R1 rsp_rdata", rsp_rdata, 64'h0);
    rd_reg(cfg_addr(5), d); chk("R1 cfg line 5", d, 64'h0);
    rd_reg(12'h008, d);     chk("R1 latch", d, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        wr_reg(VECS[i].addr, VECS[i].data);
      end else begin
        rd_reg(VECS[i].addr, d);
        chk($sformatf("R%0d table[%0d]", VECS[i].req, i), d, VECS[i].data);
      end
    end

    // R4 data register with and without inversion
    rd_reg(12'h000, d); chk("R4 plain read", d, 64'hA5A5_0000_1234_5678);
    // R5 readback keeps only defined fields
    wr_reg(cfg_addr(3), 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(cfg_addr(3), d); chk("R5 field mask", d, 64'h0000_0000_03FF_1003);
    wr_reg(cfg_addr(3), 64'h2);
    rd_reg(cfg_addr(3), d); chk("R5 invert only", d, 64'h2);
    rd_reg(12'h000, d); chk("R4 inverted line 3", d, 64'hA5A5_0000_1234_5670);
    pad_in = 64'h0;
    rd_reg(12'h000, d); chk("R4 zero pins", d, 64'h8);
    // R5 out-of-range line number
    wr_reg(cfg_addr(N), 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(cfg_addr(N), d); chk("R5 out-of-range read", d, 64'h0);
    rd_reg(cfg_addr(0), d); chk("R5 no alias to line 0", d, 64'h0);
    chk("R5 no pad change", 64'(pad_oe), 64'h0);

    // R6 push-pull on line 7
    wr_reg(cfg_addr(7), 64'h1); settle();
    chk("R6 oe line7", 64'(pad_oe[7]), 64'h1);
    chk("R6 out low", 64'(pad_out[7]), 64'h0);
    wr_reg(12'h008, 64'h80); settle();
    chk("R6 out high", 64'(pad_out[7]), 64'h1);
    wr_reg(cfg_addr(7), 64'h3); settle();
    chk("R6 inverted out", 64'(pad_out[7]), 64'h0);

    // R7 open-drain on line 9
    wr_reg(cfg_addr(9), 64'h1001); settle();
    chk("R7 latch0 released", 64'(pad_oe[9]), 64'h0);
    wr_reg(12'h008, 64'h200); settle();
    chk("R7 latch1 pulls low oe", 64'(pad_oe[9]), 64'h1);
    chk("R7 latch1 out", 64'(pad_out[9]), 64'h0);
    wr_reg(cfg_addr(9), 64'h1003); settle();
    chk("R7 inverted released", 64'(pad_oe[9]), 64'h0);

    // R8 owned line 7 released, latch still works
    wr_reg(cfg_addr(7), 64'h0001_0001); settle();
    chk("R8 owned oe", 64'(pad_oe[7]), 64'h0);
    chk("R8 owned out", 64'(pad_out[7]), 64'h0);
    wr_reg(12'h010, 64'h80);
    rd_reg(12'h008, d); chk("R8 latch writable", d, 64'h200);

    // R10 idle cycle returns zero
    @(negedge clk);
    chk("R10 idle rdata", rsp_rdata, 64'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule